// File: doc/BRIEF.md
# VLAN Slice Decapsulation Classifier

This block takes tunnelled frames one byte per beat. Each frame is Ethernet with an 802.1Q tag, then IPv4 without options, then UDP. The block checks each frame and decides which virtual slice it belongs to. The low bits of the VLAN tag index a slice table. Each table entry holds a 4-bit code option, a 32-bit slice data pointer and a 16-bit slice data size. A code option of zero means the slice is switched off.

A frame that passes every check produces one metadata record for the next pipeline stage. The record holds:
- the buffer handle;
- the offset and length of the inner frame (the UDP payload);
- the slice index and the receive ID;
- the tunnel source address and both UDP ports;
- the table entry.

Every other frame is dropped. Its cause is counted in a saturating counter.

Software loads the table and the local MAC address through plain write pins. Both streams use valid/ready:
- A byte moves when `in_valid` and `in_ready` are both high.
- A record moves when `out_valid` and `out_ready` are both high.
- A record that has not been taken holds the output and stalls the byte stream. `in_ready` equals `!out_valid || out_ready`, so the block adds no stall cycle when the consumer is ready.

Top module: `slice_decap_classifier`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, every counter reads 0, every slice's code option is 0 and the local MAC is 0.
- R2: The slice index is the low SLICE_W bits of the tag control field (byte 14 is the high byte, byte 15 the low byte). The upper tag bits are ignored. The record carries this index and that entry's code option, pointer and size.
- R3: A frame whose slice entry has code option 0 is dropped under cause 5, and no record is produced.
- R4: The record's receive ID is the low 4 bits of byte 5, which is the last byte of the destination MAC.
- R5: The record carries the tunnel source IPv4 address (bytes 30..33), the UDP source port (bytes 38..39) and the UDP destination port (bytes 40..41). Each field is most significant byte first.
- R6: The record's inner offset is always 46. Its inner length is the UDP length (bytes 42..43) minus 8.
- R7: A frame whose bytes 0..5 differ from the configured local MAC (most significant byte first) is dropped under cause 1.
- R8: A frame is dropped under cause 2 if any of the following holds: bytes 12..13 are not 0x8100, bytes 16..17 are not 0x0800, the IP version nibble (byte 18, bits 7:4) is not 4, or the UDP length is below 8.
- R9: A frame whose header-length nibble (byte 18, bits 3:0) is not 5 is dropped under cause 3. A frame whose protocol byte (byte 27) is not 17 is dropped under cause 4.
- R10: A frame shorter than 46 bytes is dropped under cause 0. A dropped frame increments exactly one counter: the lowest-numbered cause that applies.
- R11: Drop counter for cause g sits at bits [g*CNT_W +: CNT_W] of `drop_counts`. `accept_count` counts records produced. Every counter stops at all ones.
- R12: While `out_valid` is high and `out_ready` is low, the record stays unchanged and `in_ready` is low.
- R13: A table write in the same beat as byte 15 of a frame, or later, does not change that frame's record. The next frame sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Byte beat accepted when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_handle | input | HANDLE_W | Buffer handle, taken from the first byte's beat |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_handle | output | HANDLE_W | Buffer handle of the frame |
| out_offset | output | 16 | Inner-frame offset in bytes |
| out_length | output | 16 | Inner-frame length in bytes |
| out_slice | output | SLICE_W | Slice index |
| out_rxid | output | 4 | Receive ID |
| out_src_ip | output | 32 | Tunnel source IPv4 address |
| out_src_port | output | 16 | UDP source port |
| out_dst_port | output | 16 | UDP destination port |
| out_code | output | 4 | Slice code option |
| out_sptr | output | 32 | Slice data pointer |
| out_ssize | output | 16 | Slice data size |
| tbl_we | input | 1 | Slice table write strobe |
| tbl_idx | input | SLICE_W | Slice table entry written |
| tbl_code | input | 4 | Code option to write |
| tbl_ptr | input | 32 | Slice data pointer to write |
| tbl_size | input | 16 | Slice data size to write |
| mac_we | input | 1 | Local MAC write strobe |
| mac_addr | input | 48 | Local MAC value |
| drop_counts | output | 6*CNT_W | Per-cause drop counters |
| accept_count | output | CNT_W | Records produced |

## Verification
The bench builds the block with SLICE_W = 4 and CNT_W = 3.

With a 16-entry table, the bench can set up every interesting case with a few writes:
- an idle entry;
- entries whose tag carries set upper bits that must be ignored;
- the top index.

With 3-bit counters, saturation comes after seven events. The bench therefore drives the cause-1 counter and the accept counter past their limit in a few dozen frames and confirms that they hold at 7 and do not wrap.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int N_CAUSE   = 6;
  localparam int HDR_BYTES = 46;

  typedef enum logic [2:0] {
    C_SHORT     = 3'd0,
    C_MAC       = 3'd1,
    C_ENCAP     = 3'd2,
    C_OPTS      = 3'd3,
    C_PROTO     = 3'd4,
    C_SLICE_OFF = 3'd5
  } cause_e;

  typedef struct packed {
    logic [3:0]  code;
    logic [31:0] ptr;
    logic [15:0] size;
  } slice_ent_t;

  typedef struct packed {
    logic [31:0] src_ip;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [15:0] udp_len;
    logic [3:0]  rxid;
  } tunnel_t;
endpackage

// File: rtl/sdc_slice_table.sv
module sdc_slice_table
  import sdc_pkg::*;
#(
  parameter int SLICE_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLICE_W-1:0] wr_idx,
  input  slice_ent_t         wr_ent,
  input  logic               rd_en,
  input  logic [SLICE_W-1:0] rd_idx,
  output slice_ent_t         rd_ent
);
  localparam int DEPTH = 1 << SLICE_W;

  logic [3:0]  code_mem [DEPTH];
  logic [31:0] ptr_mem  [DEPTH];
  logic [15:0] size_mem [DEPTH];

  // code options reset to zero so every slice starts switched off
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) code_mem[k] <= 4'd0;
    end else if (wr_en) begin
      code_mem[wr_idx] <= wr_ent.code;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ptr_mem[wr_idx]  <= wr_ent.ptr;
      size_mem[wr_idx] <= wr_ent.size;
    end
  end

  // snapshot read: a write in the same edge is seen only by later reads
  always_ff @(posedge clk) begin
    if (!rst_n) rd_ent <= '0;
    else if (rd_en) rd_ent <= '{code: code_mem[rd_idx], ptr: ptr_mem[rd_idx], size: size_mem[rd_idx]};
  end
endmodule

// File: rtl/sdc_hdr_parser.sv
module sdc_hdr_parser
  import sdc_pkg::*;
#(
  parameter int SLICE_W  = 11,
  parameter int HANDLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat,
  input  logic [7:0]          data,
  input  logic                last,
  input  logic [HANDLE_W-1:0] handle,
  input  logic [47:0]         mac,
  input  logic [3:0]          lk_code,
  output logic                lk_en,
  output logic [SLICE_W-1:0]  lk_idx,
  output logic [SLICE_W-1:0]  slice_idx,
  output logic                frame_end,
  output logic                frame_ok,
  output cause_e              frame_cause,
  output tunnel_t             tun,
  output logic [HANDLE_W-1:0] cap_handle
);
  localparam logic [5:0] POS_MAX  = 6'(HDR_BYTES);
  localparam logic [5:0] POS_TAIL = 6'(HDR_BYTES - 1);

  logic [5:0] pos;
  logic       f_mac, f_encap, f_opt, f_proto;
  logic [7:0] mac_byte;

  always_comb begin
    mac_byte = 8'h00;
    for (int k = 0; k < 6; k++)
      if (pos == 6'(k)) mac_byte = mac[8*(5-k) +: 8];
  end

  generate
    if (SLICE_W > 8) begin : g_wide
      logic [SLICE_W-9:0] hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= '0;
        else if (beat && !last && pos == 6'd14) hi_q <= data[SLICE_W-9:0];
      end
      assign lk_idx = {hi_q, data};
    end else begin : g_narrow
      assign lk_idx = data[SLICE_W-1:0];
    end
  endgenerate

  assign lk_en     = beat && !last && (pos == 6'd15);
  assign frame_end = beat && last;

  always_comb begin
    frame_ok    = 1'b0;
    frame_cause = C_SHORT;
    if (pos < POS_TAIL)                        frame_cause = C_SHORT;
    else if (f_mac)                            frame_cause = C_MAC;
    else if (f_encap || tun.udp_len < 16'd8)   frame_cause = C_ENCAP;
    else if (f_opt)                            frame_cause = C_OPTS;
    else if (f_proto)                          frame_cause = C_PROTO;
    else if (lk_code == 4'd0)                  frame_cause = C_SLICE_OFF;
    else                                       frame_ok    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; f_mac <= 1'b0; f_encap <= 1'b0; f_opt <= 1'b0; f_proto <= 1'b0;
      tun <= '0; cap_handle <= '0; slice_idx <= '0;
    end else if (beat) begin
      if (last) begin
        pos <= '0; f_mac <= 1'b0; f_encap <= 1'b0; f_opt <= 1'b0; f_proto <= 1'b0;
      end else begin
        if (pos != POS_MAX) pos <= pos + 6'd1;
        if (pos < 6'd6 && data != mac_byte) f_mac <= 1'b1;
        case (pos)
          6'd0:  cap_handle <= handle;
          6'd5:  tun.rxid <= data[3:0];
          6'd12: if (data != 8'h81) f_encap <= 1'b1;
          6'd13: if (data != 8'h00) f_encap <= 1'b1;
          6'd15: slice_idx <= lk_idx;
          6'd16: if (data != 8'h08) f_encap <= 1'b1;
          6'd17: if (data != 8'h00) f_encap <= 1'b1;
          6'd18: begin
            if (data[7:4] != 4'd4) f_encap <= 1'b1;
            if (data[3:0] != 4'd5) f_opt <= 1'b1;
          end
          6'd27: if (data != 8'd17) f_proto <= 1'b1;
          6'd30, 6'd31, 6'd32, 6'd33: tun.src_ip <= {tun.src_ip[23:0], data};
          6'd38, 6'd39: tun.sport   <= {tun.sport[7:0], data};
          6'd40, 6'd41: tun.dport   <= {tun.dport[7:0], data};
          6'd42, 6'd43: tun.udp_len <= {tun.udp_len[7:0], data};
          default: ;
        endcase
      end
    end
  end

  p_pos_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> pos == 6'd0);
  p_pos_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_MAX);
endmodule

// File: rtl/sdc_counters.sv
module sdc_counters
  import sdc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CAUSE-1:0]       drop_inc,
  input  logic                     acc_inc,
  output logic [N_CAUSE*CNT_W-1:0] drop_counts,
  output logic [CNT_W-1:0]         accept_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  generate
    for (genvar g = 0; g < N_CAUSE; g++) begin : g_cause
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (drop_inc[g] && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      end
      assign drop_counts[g*CNT_W +: CNT_W] = cnt_q;
      p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == TOP |=> cnt_q == TOP);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) accept_count <= '0;
    else if (acc_inc && accept_count != TOP) accept_count <= accept_count + 1'b1;
  end

  p_acc_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept_count == TOP |=> accept_count == TOP);
  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drop_inc, acc_inc}));
endmodule

// File: rtl/slice_decap_classifier.sv
module slice_decap_classifier
  import sdc_pkg::*;
#(
  parameter int SLICE_W  = 11,
  parameter int HANDLE_W = 24,
  parameter int CNT_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [7:0]               in_data,
  input  logic                     in_last,
  input  logic [HANDLE_W-1:0]      in_handle,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [HANDLE_W-1:0]      out_handle,
  output logic [15:0]              out_offset,
  output logic [15:0]              out_length,
  output logic [SLICE_W-1:0]       out_slice,
  output logic [3:0]               out_rxid,
  output logic [31:0]              out_src_ip,
  output logic [15:0]              out_src_port,
  output logic [15:0]              out_dst_port,
  output logic [3:0]               out_code,
  output logic [31:0]              out_sptr,
  output logic [15:0]              out_ssize,
  input  logic                     tbl_we,
  input  logic [SLICE_W-1:0]       tbl_idx,
  input  logic [3:0]               tbl_code,
  input  logic [31:0]              tbl_ptr,
  input  logic [15:0]              tbl_size,
  input  logic                     mac_we,
  input  logic [47:0]              mac_addr,
  output logic [N_CAUSE*CNT_W-1:0] drop_counts,
  output logic [CNT_W-1:0]         accept_count
);
  logic                beat;
  logic [47:0]         local_mac;
  slice_ent_t          wr_ent, lk_ent;
  logic                lk_en;
  logic [SLICE_W-1:0]  lk_idx, slice_idx;
  logic                frame_end, frame_ok;
  cause_e              frame_cause;
  tunnel_t             tun;
  logic [HANDLE_W-1:0] cap_handle;
  logic [N_CAUSE-1:0]  drop_inc;

  assign in_ready   = !out_valid || out_ready;
  assign beat       = in_valid && in_ready;
  assign wr_ent     = '{code: tbl_code, ptr: tbl_ptr, size: tbl_size};
  assign out_offset = 16'(HDR_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) local_mac <= '0;
    else if (mac_we) local_mac <= mac_addr;
  end

  sdc_slice_table #(.SLICE_W(SLICE_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_ent(wr_ent),
    .rd_en(lk_en), .rd_idx(lk_idx), .rd_ent(lk_ent)
  );

  sdc_hdr_parser #(.SLICE_W(SLICE_W), .HANDLE_W(HANDLE_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(in_data), .last(in_last),
    .handle(in_handle), .mac(local_mac), .lk_code(lk_ent.code),
    .lk_en(lk_en), .lk_idx(lk_idx), .slice_idx(slice_idx),
    .frame_end(frame_end), .frame_ok(frame_ok), .frame_cause(frame_cause),
    .tun(tun), .cap_handle(cap_handle)
  );

  generate
    for (genvar g = 0; g < N_CAUSE; g++) begin : g_inc
      assign drop_inc[g] = frame_end && !frame_ok && (frame_cause == cause_e'(g));
    end
  endgenerate

  sdc_counters #(.CNT_W(CNT_W)) u_counters (
    .clk(clk), .rst_n(rst_n), .drop_inc(drop_inc), .acc_inc(frame_end && frame_ok),
    .drop_counts(drop_counts), .accept_count(accept_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_handle <= '0; out_length <= '0; out_slice <= '0;
      out_rxid <= '0; out_src_ip <= '0; out_src_port <= '0; out_dst_port <= '0;
      out_code <= '0; out_sptr <= '0; out_ssize <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (frame_end && frame_ok) begin
        out_valid    <= 1'b1;
        out_handle   <= cap_handle;
        out_length   <= tun.udp_len - 16'd8;
        out_slice    <= slice_idx;
        out_rxid     <= tun.rxid;
        out_src_ip   <= tun.src_ip;
        out_src_port <= tun.sport;
        out_dst_port <= tun.dport;
        out_code     <= lk_ent.code;
        out_sptr     <= lk_ent.ptr;
        out_ssize    <= lk_ent.size;
      end
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_handle) && $stable(out_length)
      && $stable(out_src_ip) && $stable(out_code) && $stable(out_sptr));
  p_live_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_code != 4'd0);
endmodule

// File: tb/sim_slice_decap_classifier.sv
`timescale 1ns/1ps
module sim_slice_decap_classifier;
  localparam int SW = 4, HW = 24, CW = 3, NC = 6;
  localparam logic [47:0] LMAC = 48'h02AABBCCDDE5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic [HW-1:0] in_handle = '0;
  logic tbl_we = 1'b0, mac_we = 1'b0;
  logic [SW-1:0] tbl_idx = '0;
  logic [3:0] tbl_code = '0;
  logic [31:0] tbl_ptr = '0;
  logic [15:0] tbl_size = '0;
  logic [47:0] mac_addr = '0;
  logic in_ready, out_valid;
  logic [HW-1:0] out_handle;
  logic [15:0] out_offset, out_length, out_src_port, out_dst_port, out_ssize;
  logic [SW-1:0] out_slice;
  logic [3:0] out_rxid, out_code;
  logic [31:0] out_src_ip, out_sptr;
  logic [NC*CW-1:0] drop_counts;
  logic [CW-1:0] accept_count;

  always #2.5 clk = ~clk;

  slice_decap_classifier #(.SLICE_W(SW), .HANDLE_W(HW), .CNT_W(CW)) u0 (.*);

  typedef struct packed {
    logic mac_bad; logic [15:0] tpid; logic [15:0] tci; logic [7:0] verihl;
    logic [7:0] proto; logic [15:0] udplen; logic [7:0] nbytes; logic [2:0] exp;
  } vec_t;
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h8100, 16'h0003, 8'h45, 8'd17, 16'd12, 8'd50, 3'd7},
    '{1'b0, 16'h8100, 16'h0A99, 8'h45, 8'd17, 16'd8,  8'd46, 3'd7},
    '{1'b0, 16'h8100, 16'h0010, 8'h45, 8'd17, 16'd12, 8'd50, 3'd5},
    '{1'b1, 16'h8100, 16'h0003, 8'h45, 8'd17, 16'd12, 8'd50, 3'd1},
    '{1'b0, 16'h88A8, 16'h0003, 8'h45, 8'd17, 16'd12, 8'd50, 3'd2},
    '{1'b0, 16'h8100, 16'h0003, 8'h46, 8'd17, 16'd12, 8'd50, 3'd3},
    '{1'b0, 16'h8100, 16'h0003, 8'h45, 8'd6,  16'd12, 8'd50, 3'd4},
    '{1'b0, 16'h8100, 16'h0003, 8'h45, 8'd17, 16'd12, 8'd40, 3'd0},
    '{1'b0, 16'h8100, 16'h0003, 8'h45, 8'd17, 16'd4,  8'd50, 3'd2},
    '{1'b0, 16'h8100, 16'h07FF, 8'h45, 8'd17, 16'd20, 8'd60, 3'd7},
    '{1'b0, 16'h8100, 16'h0003, 8'h65, 8'd17, 16'd12, 8'd50, 3'd2},
    '{1'b1, 16'h8100, 16'h0003, 8'h45, 8'd6,  16'd12, 8'd50, 3'd1},
    '{1'b0, 16'h8100, 16'h0009, 8'h45, 8'd17, 16'd12, 8'd45, 3'd0}
  };

  int n_chk = 0, n_fail = 0, got = 0, e_acc = 0, serial = 0;
  int e_drop [NC];
  logic [3:0] m_code [16];
  logic [31:0] m_ptr [16];
  logic [15:0] m_size [16];
  logic [7:0] fb [256];
  int flen;
  logic [HW-1:0] r_handle;
  logic [15:0] r_off, r_len, r_sp, r_dp, r_size;
  logic [SW-1:0] r_slice;
  logic [3:0] r_rxid, r_code;
  logic [31:0] r_ip, r_ptr;

  always @(negedge clk) if (out_valid && out_ready) begin
    got++; r_handle = out_handle; r_off = out_offset; r_len = out_length; r_slice = out_slice;
    r_rxid = out_rxid; r_ip = out_src_ip; r_sp = out_src_port; r_dp = out_dst_port;
    r_code = out_code; r_ptr = out_sptr; r_size = out_ssize;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sat(int n); return (n > 7) ? 7 : n; endfunction
  function automatic logic [CW-1:0] dcnt(int g); return CW'(drop_counts >> (g*CW)); endfunction

  task automatic tbl_write(int idx, logic [3:0] c, logic [31:0] p, logic [15:0] s);
    @(negedge clk); tbl_we = 1'b1; tbl_idx = SW'(idx); tbl_code = c; tbl_ptr = p; tbl_size = s;
    @(negedge clk); tbl_we = 1'b0;
    m_code[idx] = c; m_ptr[idx] = p; m_size[idx] = s;
  endtask

  task automatic build(logic mb, logic [15:0] tpid, logic [15:0] tci, logic [7:0] vh,
                       logic [7:0] pr, logic [31:0] sip, logic [15:0] sp, logic [15:0] dp,
                       logic [15:0] ul, int n);
    for (int i = 0; i < 256; i++) fb[i] = 8'(i * 7 + 3);
    for (int k = 0; k < 6; k++) fb[k] = LMAC[8*(5-k) +: 8];
    if (mb) fb[2] = fb[2] ^ 8'h40;
    fb[12] = tpid[15:8]; fb[13] = tpid[7:0]; fb[14] = tci[15:8]; fb[15] = tci[7:0];
    fb[16] = 8'h08; fb[17] = 8'h00; fb[18] = vh; fb[27] = pr;
    fb[30] = sip[31:24]; fb[31] = sip[23:16]; fb[32] = sip[15:8]; fb[33] = sip[7:0];
    fb[38] = sp[15:8]; fb[39] = sp[7:0]; fb[40] = dp[15:8]; fb[41] = dp[7:0];
    fb[42] = ul[15:8]; fb[43] = ul[7:0];
    flen = n;
  endtask

  task automatic send(int h, int wr_at);
    logic rdy;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == flen - 1);
      in_handle = HW'(h); tbl_we = (i == wr_at);
      forever begin
        #1 rdy = in_ready;
        @(posedge clk);
        if (rdy) break;
        @(negedge clk);
      end
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; tbl_we = 1'b0;
  endtask

  // one frame: build, send, then check record or drop counter
  task automatic run_frame(logic mb, logic [15:0] tpid, logic [15:0] tci, logic [7:0] vh,
                           logic [7:0] pr, logic [15:0] ul, int n, int exp, int wr_at);
    int g0, h, ix;
    logic [31:0] sip; logic [15:0] sp, dp;
    logic [3:0] ec; logic [31:0] ep; logic [15:0] es;
    serial++;
    sip = 32'hC0A80000 + 32'(serial); sp = 16'h1000 + 16'(serial); dp = 16'h2000 + 16'(serial * 3);
    h = 24'h5000 + serial; ix = int'(tci[SW-1:0]);
    ec = m_code[ix]; ep = m_ptr[ix]; es = m_size[ix];
    build(mb, tpid, tci, vh, pr, sip, sp, dp, ul, n);
    g0 = got;
    send(h, wr_at);
    repeat (3) @(negedge clk);
    if (exp == 7) begin
      e_acc++;
      chk("R12 record produced", 64'(got), 64'(g0 + 1));
      chk("R2 handle", 64'(r_handle), 64'(h));
      chk("R2 slice index", 64'(r_slice), 64'(ix));
      chk("R2 R13 code option", 64'(r_code), 64'(ec));
      chk("R2 pointer and size", {r_ptr, 16'h0, r_size}, {ep, 16'h0, es});
      chk("R4 receive id", 64'(r_rxid), 64'h5);
      chk("R5 tunnel fields", {r_ip, r_sp, r_dp}, {sip, sp, dp});
      chk("R6 offset and length", {r_off, r_len}, {16'd46, ul - 16'd8});
      chk("R11 accept count", 64'(accept_count), 64'(sat(e_acc)));
    end else begin
      e_drop[exp]++;
      chk(exp == 0 ? "R10 no record" : exp == 1 ? "R7 no record" : exp == 2 ? "R8 no record" :
          exp == 5 ? "R3 no record" : "R9 no record", 64'(got), 64'(g0));
      chk(exp == 0 ? "R10 cause count" : exp == 1 ? "R7 cause count" : exp == 2 ? "R8 cause count" :
          exp == 5 ? "R3 cause count" : "R9 cause count", 64'(dcnt(exp)), 64'(sat(e_drop[exp])));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g0;
    for (int i = 0; i < NC; i++) e_drop[i] = 0;
    for (int i = 0; i < 16; i++) begin m_code[i] = 4'd0; m_ptr[i] = '0; m_size[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 drop counters", 64'(drop_counts), 64'd0);
    chk("R1 accept count", 64'(accept_count), 64'd0);
    // slice 3 not yet enabled and MAC still zero: frame must be dropped under the MAC cause
    run_frame(1'b0, 16'h8100, 16'h0003, 8'h45, 8'd17, 16'd12, 50, 1, -1);

    @(negedge clk); mac_we = 1'b1; mac_addr = LMAC; @(negedge clk); mac_we = 1'b0;
    tbl_write(3, 4'd5, 32'h00300100, 16'd128);
    tbl_write(9, 4'hA, 32'h00400000, 16'd56);
    tbl_write(15, 4'd1, 32'h007FFF00, 16'd3256);

    for (int v = 0; v < NV; v++)
      run_frame(VEC[v].mac_bad, VEC[v].tpid, VEC[v].tci, VEC[v].verihl, VEC[v].proto,
                VEC[v].udplen, int'(VEC[v].nbytes), int'(VEC[v].exp), -1);

    // R12: held record stalls the byte stream
    out_ready = 1'b0;
    build(1'b0, 16'h8100, 16'h0003, 8'h45, 8'd17, 16'h0030, 8'hAA, 8'hBB, 16'd12, 50);
    g0 = got;
    send(100, -1);
    repeat (2) @(negedge clk);
    chk("R12 valid held", 64'(out_valid), 64'd1);
    chk("R12 in_ready low", 64'(in_ready), 64'd0);
    repeat (4) @(negedge clk);
    chk("R12 handle stable", 64'(out_handle), 64'd100);
    fork
      send(101, -1);
      begin
        repeat (10) @(negedge clk);
        chk("R12 nothing taken", 64'(got), 64'(g0));
        chk("R12 still first record", 64'(out_handle), 64'd100);
        @(posedge clk); #1 out_ready = 1'b1;
      end
    join
    repeat (3) @(negedge clk);
    chk("R12 both records delivered", 64'(got), 64'(g0 + 2));
    chk("R12 order", 64'(r_handle), 64'd101);
    e_acc += 2;

    // R13: turn slice 9 off in the beat of byte 15
    tbl_idx = SW'(9); tbl_code = 4'd0; tbl_ptr = 32'h1; tbl_size = 16'h1;
    run_frame(1'b0, 16'h8100, 16'h0009, 8'h45, 8'd17, 16'd12, 50, 7, 15);
    m_code[9] = 4'd0; m_ptr[9] = 32'h1; m_size[9] = 16'h1;
    run_frame(1'b0, 16'h8100, 16'h0009, 8'h45, 8'd17, 16'd12, 50, 5, -1);

    // R11: saturation of a drop counter and the accept counter
    for (int k = 0; k < 7; k++)
      run_frame(1'b1, 16'h8100, 16'h0003, 8'h45, 8'd17, 16'd12, 50, 1, -1);
    chk("R11 mac counter saturated", 64'(dcnt(1)), 64'd7);
    for (int k = 0; k < 2; k++)
      run_frame(1'b0, 16'h8100, 16'h000F, 8'h45, 8'd17, 16'd30, 52, 7, -1);
    chk("R11 accept saturated", 64'(accept_count), 64'd7);
    for (int g = 0; g < NC; g++)
      chk("R11 final cause count", 64'(dcnt(g)), 64'(sat(e_drop[g])));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule